// File: doc/BRIEF.md
# Dual-Pixel Video Output Serializer

This block sits between a 16-bit processor's output store and an 8-bit video pin group. Each store places two complete pixels in one word; the block puts the lower pixel on the video register in the next pixel period and the upper pixel one period after that. The processor therefore writes once per two pixels while each pixel still lands on an exact pixel boundary. A pixel period is any clock cycle with the pixel enable high. Scan timing is not generated here: the processor is expected to store at a fixed cadence.

Each 8-bit pixel is laid out, from bit 7 down to bit 0, as two bits of red, two of green, two of blue, then horizontal sync (bit 1) and vertical sync (bit 0). Sync is active low. A store that arrives while a word is still being shifted out is parked in a one-deep hold register and counted as an overrun. When the video register runs dry it blanks the colour and keeps the last sync levels.

Top module: `dpx_serializer`

## Requirements
- R1: While reset is asserted, and after it until the first pixel period, vid_out is 8'h03 (colour zero, both syncs at the inactive level 1) and ovr_count is 0.
- R2: vid_out changes only on a clock edge where pix_en is high.
- R3: A word accepted at a clock edge puts its bits [7:0] on vid_out at the first later edge with pix_en high.
- R4: At the next edge with pix_en high after the lower pixel, vid_out takes bits [15:8] of the same word.
- R5: A store at the same edge where the upper pixel is emitted, with no word parked, is accepted directly, so storing every second pixel period yields an unbroken pixel stream.
- R6: A store that is not accepted directly is parked (replacing any word already parked); the parked word is emitted, lower pixel first, right after the current word's upper pixel.
- R7: ovr_count increments by one for each parked store and saturates at its all-ones value.
- R8: A pixel period with no word pending drives bits [7:2] of vid_out to zero and leaves bits [1:0] unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel period enable, one cycle per pixel |
| wr_en | input | 1 | Store strobe for wr_data |
| wr_data | input | 16 | Two pixels; bits [7:0] go out first |
| vid_out | output | 8 | Registered video pixel RRGGBBHV |
| ovr_count | output | 8 | Saturating count of parked stores |

## Verification
The hardest state to reach is a store that lands on the very edge where the upper pixel leaves while another word is already parked: the parked word must advance and the new store must take its place and count as an overrun. Random stimulus with a high store rate and a sparse pixel enable reaches it often, and a directed burst of several hundred stores with pix_en held low drives the overrun count into saturation before the parked word is drained.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/dpx_half_sel.sv
module dpx_half_sel #(
    parameter int PIX_W     = 8,
    parameter bit LOW_FIRST = 1'b1
) (
    input  logic [2*PIX_W-1:0] word,
    input  logic               second,
    output logic [PIX_W-1:0]   pix
);
    generate
        if (LOW_FIRST) begin : g_low_first
            assign pix = second ? word[2*PIX_W-1:PIX_W] : word[PIX_W-1:0];
        end else begin : g_high_first
            assign pix = second ? word[PIX_W-1:0] : word[2*PIX_W-1:PIX_W];
        end
    endgenerate
endmodule

// File: rtl/dpx_sat_counter.sv
module dpx_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/dpx_serializer.sv
module dpx_serializer #(
    parameter int PIX_W     = 8,
    parameter int SYNC_W    = 2,
    parameter int OVR_W     = 8,
    parameter bit LOW_FIRST = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pix_en,
    input  logic                 wr_en,
    input  logic [2*PIX_W-1:0]   wr_data,
    output logic [PIX_W-1:0]     vid_out,
    output logic [OVR_W-1:0]     ovr_count
);
    import dpx_pkg::*;

    localparam int WORD_W = 2 * PIX_W;
    localparam int COL_W  = PIX_W - SYNC_W;
    localparam logic [PIX_W-1:0] VID_RST = {{COL_W{1'b0}}, {SYNC_W{1'b1}}};

    typedef struct packed {
        phase_e              phase;
        logic [WORD_W-1:0]   word;
        logic [WORD_W-1:0]   park;
        logic                park_v;
        logic [PIX_W-1:0]    vid;
    } state_t;

    state_t st_d, st_q;
    logic   direct;
    logic   park_inc;
    logic   take_second;
    logic [PIX_W-1:0] half_pix;

    assign take_second = (st_q.phase == PH_HIGH);

    dpx_half_sel #(
        .PIX_W     (PIX_W),
        .LOW_FIRST (LOW_FIRST)
    ) u_sel (
        .word   (st_q.word),
        .second (take_second),
        .pix    (half_pix)
    );

    always_comb begin
        st_d   = st_q;
        direct = wr_en && ((st_q.phase == PH_IDLE) ||
                           (st_q.phase == PH_HIGH && pix_en && !st_q.park_v));
        park_inc = wr_en && !direct;

        if (pix_en) begin
            unique case (st_q.phase)
                PH_LOW: begin
                    st_d.vid   = half_pix;
                    st_d.phase = PH_HIGH;
                end
                PH_HIGH: begin
                    st_d.vid = half_pix;
                    if (st_q.park_v) begin
                        st_d.word   = st_q.park;
                        st_d.park_v = 1'b0;
                        st_d.phase  = PH_LOW;
                    end else begin
                        st_d.phase = PH_IDLE;
                    end
                end
                default: begin
                    st_d.vid = {{COL_W{1'b0}}, st_q.vid[SYNC_W-1:0]};
                end
            endcase
        end

        if (direct) begin
            st_d.word  = wr_data;
            st_d.phase = PH_LOW;
        end else if (park_inc) begin
            st_d.park   = wr_data;
            st_d.park_v = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.word   <= '0;
            st_q.park   <= '0;
            st_q.park_v <= 1'b0;
            st_q.vid    <= VID_RST;
        end else begin
            st_q <= st_d;
        end
    end

    dpx_sat_counter #(
        .W (OVR_W)
    ) u_ovr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (park_inc),
        .count (ovr_count)
    );

    assign vid_out = st_q.vid;
endmodule

// File: rtl/dpx_serializer_chk.sv
module dpx_serializer_chk #(
    parameter int PIX_W = 8,
    parameter int OVR_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pix_en,
    input logic [1:0]         phase,
    input logic [2*PIX_W-1:0] word,
    input logic [PIX_W-1:0]   vid_out,
    input logic [OVR_W-1:0]   ovr_count
);
    // R2: output register moves only in a pixel period
    a_r2_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(vid_out));

    // R3: lower pixel leaves first
    a_r3_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && phase == 2'd1) |=> vid_out == $past(word[PIX_W-1:0]));

    // R4: upper pixel follows
    a_r4_high_next: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && phase == 2'd2) |=> vid_out == $past(word[2*PIX_W-1:PIX_W]));

    // R7: count never falls, and stays at its ceiling
    a_r7_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ovr_count >= $past(ovr_count));

    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_count == {OVR_W{1'b1}}) |=> $stable(ovr_count));

    // R8: blank colour, keep sync
    a_r8_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && phase == 2'd0) |=>
            (vid_out[PIX_W-1:2] == '0 && vid_out[1:0] == $past(vid_out[1:0])));
endmodule

bind dpx_serializer dpx_serializer_chk #(
    .PIX_W (PIX_W),
    .OVR_W (OVR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_en    (pix_en),
    .phase     (st_q.phase),
    .word      (st_q.word),
    .vid_out   (vid_out),
    .ovr_count (ovr_count)
);

// File: tb/dpx_serializer_tb.sv
module dpx_serializer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  vid_out;
    logic [7:0]  ovr_count;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int          m_phase = 0;
    logic [15:0] m_word = '0;
    logic [15:0] m_park = '0;
    logic        m_park_v = 1'b0;
    logic [7:0]  m_vid = 8'h03;
    logic [7:0]  m_cnt = '0;
    string       m_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    dpx_serializer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_en    (pix_en),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .vid_out   (vid_out),
        .ovr_count (ovr_count)
    );

    function automatic logic [7:0] blank(input logic [7:0] v);
        return {6'b0, v[1:0]};
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // advance the model by one clock edge with the given inputs
    task automatic model_step(input logic wr, input logic [15:0] wd, input logic pe);
        logic direct;
        int   ph0;
        ph0    = m_phase;
        direct = wr && (ph0 == 0 || (ph0 == 2 && pe && !m_park_v));
        m_tag  = "R2";
        if (pe) begin
            if (ph0 == 0) begin
                m_vid = blank(m_vid);
                m_tag = "R8";
            end else if (ph0 == 1) begin
                m_vid   = m_word[7:0];
                m_phase = 2;
                m_tag   = "R3";
            end else begin
                m_vid = m_word[15:8];
                m_tag = "R4";
                if (m_park_v) begin
                    m_word   = m_park;
                    m_park_v = 1'b0;
                    m_phase  = 1;
                    m_tag    = "R6";
                end else begin
                    m_phase = 0;
                end
            end
        end
        if (direct) begin
            m_word  = wd;
            m_phase = 1;
            if (ph0 == 2) m_tag = "R5";
        end else if (wr) begin
            m_park   = wd;
            m_park_v = 1'b1;
            if (m_cnt != 8'hFF) m_cnt = m_cnt + 1'b1;
        end
    endtask

    // drive at negedge, check at the following negedge
    task automatic cycle(input logic wr, input logic [15:0] wd, input logic pe);
        wr_en   = wr;
        wr_data = wd;
        pix_en  = pe;
        model_step(wr, wd, pe);
        @(negedge clk);
        check8(m_tag, vid_out, m_vid);
        check8("R7", ovr_count, m_cnt);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check8("R1", vid_out, 8'h03);
        check8("R1", ovr_count, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check8("R1", vid_out, 8'h03);

        // idle pixel periods keep reset sync, zero colour (R8)
        for (int i = 0; i < 3; i++) cycle(1'b0, 16'h0, 1'b1);

        // single word, gaps between pixel periods (R2, R3, R4)
        cycle(1'b1, 16'hA5C3, 1'b0);
        cycle(1'b0, 16'h0, 1'b0);
        cycle(1'b0, 16'h0, 1'b1);
        cycle(1'b0, 16'h0, 1'b0);
        cycle(1'b0, 16'h0, 1'b1);
        cycle(1'b0, 16'h0, 1'b1);

        // unbroken stream: store on each upper-pixel edge (R5)
        cycle(1'b1, 16'h1102, 1'b1);
        for (int i = 0; i < 40; i++) begin
            cycle(1'b0, 16'h0, 1'b1);
            cycle(1'b1, 16'($urandom()), 1'b1);
        end
        cycle(1'b0, 16'h0, 1'b1);
        cycle(1'b0, 16'h0, 1'b1);
        cycle(1'b0, 16'h0, 1'b1);

        // parking and overwrite of the parked word (R6)
        cycle(1'b1, 16'h1234, 1'b0);
        cycle(1'b1, 16'hDEAD, 1'b0);
        cycle(1'b1, 16'hBEEF, 1'b0);
        for (int i = 0; i < 6; i++) cycle(1'b0, 16'h0, 1'b1);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            cycle(($urandom() % 3) == 0, 16'($urandom()), ($urandom() % 2) == 0);
        end

        // saturation of the overrun count (R7)
        cycle(1'b1, 16'h4444, 1'b0);
        for (int i = 0; i < 300; i++) cycle(1'b1, 16'($urandom()), 1'b0);
        for (int i = 0; i < 6; i++) cycle(1'b0, 16'h0, 1'b1);
        check8("R7", ovr_count, 8'hFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule